// File: doc/BRIEF.md
# Byte-Port Sample Buffer with Free-Space Threshold

This block holds converter results between the conversion engine and a host bus. Each 16-bit sample is stored as two bytes in a buffer of 4096 bytes (2048 samples). The host drains it one byte at a time through a single data port, and the low byte of each sample comes first. A level flag and a latched threshold event tell the host when the buffer is close to full. Either event can raise an interrupt request.

The same data port has a second use. A command write with bit 0 clear puts the port in program mode. In that mode, byte writes load two 16-bit thresholds, low byte first: first the near-empty level, then the near-full level. The near-full level is given as the number of free bytes that remain when the flag should assert, not as a fill level. A command write with bit 0 set returns the port to sample data. A command write with bit 6 set empties the buffer. A status byte reports the flags and the latched events. Reading the status byte clears the end-of-scan and threshold events.

Top module: `sample_byte_fifo`

## Requirements
- R1: After reset the port is in data mode, the status byte reads 0x01, `irq` is 0, `nearEmpty` is 1, the near-empty level is 0 and the near-full level is 2048 free bytes.
- R2: A stored sample is returned as two `portRead` bytes, low byte then high byte, and samples come out in arrival order. `portRData` shows the byte at the head, and a read pops it only when the buffer is not empty.
- R3: A sample that arrives with fewer than 2 free bytes is dropped, and status bit 5 (data lost) sets. Bit 5 stays set through status reads and clears only on a flush command.
- R4: Status bit 0 is 1 when the buffer holds no bytes. Bit 2 (full) is 1 when fewer than 2 bytes are free. Bit 1 (near-full) is 1 while the free bytes are less than or equal to the near-full level. Bits 7:6 read 0.
- R5: Command bit 0 selects the data port function: 1 selects sample data and 0 selects threshold programming. A port write in data mode changes nothing, and a port read in program mode pops nothing.
- R6: In program mode, port writes 1 and 2 load the near-empty level (low byte, then high byte) and writes 3 and 4 load the near-full level in the same order. Later writes are ignored, and every command write restarts the sequence.
- R7: Status bit 3 (threshold) latches on the accepted sample write that takes the free-byte count from above the near-full level to at or below it.
- R8: Status bit 4 (end of scan) latches on an `eosIn` pulse.
- R9: A `statusRead` strobe clears bits 4 and 3 after the cycle in which they are read. An event that arrives in the same cycle as the strobe stays set.
- R10: `irq` is 1 exactly when bit 3 is set and control bit 3 is 1, or when bit 4 is set and control bit 4 is 1.
- R11: A command write with bit 6 set empties the buffer and clears the data-lost bit.
- R12: `nearEmpty` is 1 while the stored byte count is less than or equal to the near-empty level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Converter presents a sample this cycle |
| sampleData | input | 16 | Converter sample |
| eosIn | input | 1 | End-of-scan pulse from the sequencer |
| cmdWrite | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command: bit 6 flush, bit 0 data/program select |
| ctlWrite | input | 1 | Control byte strobe |
| ctlByte | input | 8 | Control: bit 4 end-of-scan irq enable, bit 3 threshold irq enable |
| portWrite | input | 1 | Data port write strobe |
| portWData | input | 8 | Data port write byte |
| portRead | input | 1 | Data port read strobe (pops one byte) |
| portRData | output | 8 | Byte at the buffer head |
| statusRead | input | 1 | Status read strobe (clears bits 4:3) |
| statusByte | output | 8 | Status flags and latched events |
| irq | output | 1 | Interrupt request |
| nearEmpty | output | 1 | Stored bytes at or below the near-empty level |

## Verification
The properties assume the host issues at most one command write in a cycle, and that a flush is the only command that sits beside a sample or an end-of-scan pulse. The stimulus drives every strobe for exactly one cycle between falling edges and never combines a flush with a sample arrival. The properties also assume that data-lost can only be cleared by the flush command. The bench therefore reads status repeatedly while data-lost is set, to show that a status read leaves it standing.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // command byte bit positions
  localparam int CMD_DATA_SEL = 0;
  localparam int CMD_FLUSH    = 6;
  // control byte bit positions
  localparam int CTL_THR_IE   = 3;
  localparam int CTL_EOS_IE   = 4;
  // status byte bit positions
  localparam int ST_EMPTY     = 0;
  localparam int ST_NEARFULL  = 1;
  localparam int ST_FULL      = 2;
  localparam int ST_THR       = 3;
  localparam int ST_EOS       = 4;
  localparam int ST_LOST      = 5;
  localparam int THR_W        = 16;

  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
  } fifo_strobe_t;
endpackage

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int CAP_BYTES = 4096
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  fifo_strobe_t                     stb,
  input  logic [15:0]                      sampleData,
  output logic [$clog2(CAP_BYTES+1)-1:0]   byteCount,
  output logic [7:0]                       headByte
);
  localparam int WORDS = CAP_BYTES / 2;
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = $clog2(CAP_BYTES + 1);

  logic [15:0]   mem [WORDS];
  logic [AW-1:0] wrPtr;
  logic [AW:0]   rdPtr;
  logic [CW-1:0] countNext;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= sampleData;
  end

  always_comb begin
    countNext = byteCount;
    if (stb.push) countNext = countNext + CW'(2);
    if (stb.pop)  countNext = countNext - CW'(1);
    if (stb.flush) countNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      byteCount <= '0;
    end else begin
      byteCount <= countNext;
      if (stb.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (stb.push) wrPtr <= wrPtr + AW'(1);
        if (stb.pop)  rdPtr <= rdPtr + (AW+1)'(1);
      end
    end
  end

  logic [15:0] headWord;
  assign headWord = mem[rdPtr[AW:1]];
  assign headByte = rdPtr[0] ? headWord[15:8] : headWord[7:0];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int CAP_BYTES = 4096
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic                             eosIn,
  input  logic                             cmdWrite,
  input  logic [7:0]                       cmdByte,
  input  logic                             ctlWrite,
  input  logic [7:0]                       ctlByte,
  input  logic                             portWrite,
  input  logic [7:0]                       portWData,
  input  logic                             portRead,
  input  logic                             statusRead,
  input  logic [$clog2(CAP_BYTES+1)-1:0]   byteCount,
  output fifo_strobe_t                     stb,
  output logic [7:0]                       statusByte,
  output logic                             irq,
  output logic                             nearEmpty
);
  localparam int CW = $clog2(CAP_BYTES + 1);
  localparam int EW = THR_W + 1;

  logic              dataMode;
  logic              thrIe, eosIe;
  logic [1:0]        progIdx;
  logic              progDone;
  logic [THR_W-1:0]  nearEmptyLvl, nearFullLvl;
  logic              lostFlag, eosFlag, thrFlag;

  logic              flushCmd, canPush, thrHit;
  logic [EW-1:0]     freeNow, freeNext;

  logic unusedCmdBits;
  assign unusedCmdBits = ^{cmdByte[7], cmdByte[5:1], ctlByte[7:5], ctlByte[2:0]};

  assign flushCmd = cmdWrite && cmdByte[CMD_FLUSH];
  assign freeNow  = EW'(CAP_BYTES) - EW'(byteCount);
  assign canPush  = freeNow >= EW'(2);

  always_comb begin
    stb.flush = flushCmd;
    stb.push  = sampleValid && canPush && !flushCmd;
    stb.pop   = portRead && dataMode && (byteCount != '0) && !flushCmd;
  end

  always_comb begin
    freeNext = freeNow;
    if (stb.push) freeNext = freeNext - EW'(2);
    if (stb.pop)  freeNext = freeNext + EW'(1);
  end

  assign thrHit = stb.push && (freeNow > EW'(nearFullLvl)) && (freeNext <= EW'(nearFullLvl));

  // command and control registers, threshold programming sequence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataMode     <= 1'b1;
      thrIe        <= 1'b0;
      eosIe        <= 1'b0;
      progIdx      <= '0;
      progDone     <= 1'b0;
      nearEmptyLvl <= '0;
      nearFullLvl  <= THR_W'(CAP_BYTES / 2);
    end else begin
      if (ctlWrite) begin
        thrIe <= ctlByte[CTL_THR_IE];
        eosIe <= ctlByte[CTL_EOS_IE];
      end
      if (cmdWrite) begin
        dataMode <= cmdByte[CMD_DATA_SEL];
        progIdx  <= '0;
        progDone <= 1'b0;
      end else if (portWrite && !dataMode && !progDone) begin
        case (progIdx)
          2'd0: nearEmptyLvl[7:0]  <= portWData;
          2'd1: nearEmptyLvl[15:8] <= portWData;
          2'd2: nearFullLvl[7:0]   <= portWData;
          default: nearFullLvl[15:8] <= portWData;
        endcase
        progIdx <= progIdx + 2'd1;
        if (progIdx == 2'd3) progDone <= 1'b1;
      end
    end
  end

  // latched events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lostFlag <= 1'b0;
      eosFlag  <= 1'b0;
      thrFlag  <= 1'b0;
    end else begin
      if (flushCmd) lostFlag <= 1'b0;
      else if (sampleValid && !canPush) lostFlag <= 1'b1;

      if (eosIn) eosFlag <= 1'b1;
      else if (statusRead) eosFlag <= 1'b0;

      if (thrHit) thrFlag <= 1'b1;
      else if (statusRead) thrFlag <= 1'b0;
    end
  end

  always_comb begin
    statusByte              = '0;
    statusByte[ST_EMPTY]    = (byteCount == '0);
    statusByte[ST_NEARFULL] = (freeNow <= EW'(nearFullLvl));
    statusByte[ST_FULL]     = !canPush;
    statusByte[ST_THR]      = thrFlag;
    statusByte[ST_EOS]      = eosFlag;
    statusByte[ST_LOST]     = lostFlag;
  end

  assign irq       = (thrFlag && thrIe) || (eosFlag && eosIe);
  assign nearEmpty = (EW'(byteCount) <= EW'(nearEmptyLvl));
endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
  import sfifo_pkg::*;
#(
  parameter int CAP_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [15:0] sampleData,
  input  logic        eosIn,
  input  logic        cmdWrite,
  input  logic [7:0]  cmdByte,
  input  logic        ctlWrite,
  input  logic [7:0]  ctlByte,
  input  logic        portWrite,
  input  logic [7:0]  portWData,
  input  logic        portRead,
  output logic [7:0]  portRData,
  input  logic        statusRead,
  output logic [7:0]  statusByte,
  output logic        irq,
  output logic        nearEmpty
);
  localparam int CW = $clog2(CAP_BYTES + 1);

  fifo_strobe_t  stb;
  logic [CW-1:0] byteCount;

  sfifo_ctrl #(.CAP_BYTES(CAP_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .eosIn(eosIn),
    .cmdWrite(cmdWrite), .cmdByte(cmdByte), .ctlWrite(ctlWrite), .ctlByte(ctlByte),
    .portWrite(portWrite), .portWData(portWData), .portRead(portRead),
    .statusRead(statusRead), .byteCount(byteCount), .stb(stb),
    .statusByte(statusByte), .irq(irq), .nearEmpty(nearEmpty)
  );

  sfifo_datapath #(.CAP_BYTES(CAP_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleData(sampleData),
    .byteCount(byteCount), .headByte(portRData)
  );
endmodule

// File: rtl/sample_byte_fifo_checker.sv
module sample_byte_fifo_checker
  import sfifo_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         sampleValid,
  input logic         eosIn,
  input logic         cmdWrite,
  input logic [7:0]   cmdByte,
  input logic [7:0]   statusByte,
  input logic         irq,
  input fifo_strobe_t stb
);
  logic flushing;
  assign flushing = cmdWrite && cmdByte[CMD_FLUSH];

  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[ST_FULL] && sampleValid && !flushing) |=> statusByte[ST_LOST]);

  assert_lost_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[ST_LOST] && !flushing) |=> statusByte[ST_LOST]);

  assert_empty_not_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[ST_EMPTY] && statusByte[ST_FULL]));

  assert_pop_needs_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !statusByte[ST_EMPTY]);

  assert_eos_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    eosIn |=> statusByte[ST_EOS]);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusByte[ST_THR] || statusByte[ST_EOS]));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    flushing |=> (statusByte[ST_EMPTY] && !statusByte[ST_LOST]));
endmodule

bind sample_byte_fifo sample_byte_fifo_checker u_checker (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .eosIn(eosIn),
  .cmdWrite(cmdWrite), .cmdByte(cmdByte), .statusByte(statusByte),
  .irq(irq), .stb(stb)
);

// File: tb/sample_byte_fifo_bench.sv
module sample_byte_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 29;
  // ops
  localparam logic [2:0] OP_PUSH = 3'd0, OP_RDB = 3'd1, OP_STAT = 3'd2, OP_CMD = 3'd3,
                         OP_PROG = 3'd4, OP_CTL = 3'd5, OP_EOS = 3'd6, OP_IRQ = 3'd7;

  // {op, arg, expected}
  localparam logic [34:0] VEC [NVEC] = '{
    {OP_PUSH, 16'h1234, 16'h0000},
    {OP_PUSH, 16'hABCD, 16'h0000},
    {OP_STAT, 16'h0000, 16'h0000},
    {OP_RDB,  16'h0000, 16'h0034},   // R2 low byte first
    {OP_RDB,  16'h0000, 16'h0012},
    {OP_RDB,  16'h0000, 16'h00CD},
    {OP_RDB,  16'h0000, 16'h00AB},
    {OP_STAT, 16'h0000, 16'h0001},
    {OP_CMD,  16'h0000, 16'h0000},   // R6 program mode
    {OP_PROG, 16'h0002, 16'h0000},
    {OP_PROG, 16'h0000, 16'h0000},
    {OP_PROG, 16'h00FA, 16'h0000},
    {OP_PROG, 16'h000F, 16'h0000},   // near-full level 4090 free bytes
    {OP_CMD,  16'h0001, 16'h0000},
    {OP_CTL,  16'h0008, 16'h0000},
    {OP_PUSH, 16'h1111, 16'h0000},
    {OP_IRQ,  16'h0000, 16'h0000},
    {OP_PUSH, 16'h2222, 16'h0000},
    {OP_IRQ,  16'h0000, 16'h0000},
    {OP_PUSH, 16'h3333, 16'h0000},   // R7 free 4092 -> 4090
    {OP_IRQ,  16'h0000, 16'h0001},
    {OP_STAT, 16'h0000, 16'h000A},
    {OP_IRQ,  16'h0000, 16'h0000},
    {OP_STAT, 16'h0000, 16'h0002},
    {OP_EOS,  16'h0000, 16'h0000},   // R8
    {OP_IRQ,  16'h0000, 16'h0000},
    {OP_STAT, 16'h0000, 16'h0012},
    {OP_CMD,  16'h0041, 16'h0000},   // R11 flush
    {OP_STAT, 16'h0000, 16'h0001}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleValid = 1'b0, eosIn = 1'b0, cmdWrite = 1'b0, ctlWrite = 1'b0;
  logic portWrite = 1'b0, portRead = 1'b0, statusRead = 1'b0;
  logic [15:0] sampleData = '0;
  logic [7:0]  cmdByte = '0, ctlByte = '0, portWData = '0;
  logic [7:0]  portRData, statusByte;
  logic        irq, nearEmpty;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_byte_fifo u_sample_byte_fifo (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .eosIn(eosIn), .cmdWrite(cmdWrite), .cmdByte(cmdByte), .ctlWrite(ctlWrite),
    .ctlByte(ctlByte), .portWrite(portWrite), .portWData(portWData),
    .portRead(portRead), .portRData(portRData), .statusRead(statusRead),
    .statusByte(statusByte), .irq(irq), .nearEmpty(nearEmpty)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    sampleValid = 1'b1; sampleData = d;
    @(negedge clk); sampleValid = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b);
    cmdWrite = 1'b1; cmdByte = b;
    @(negedge clk); cmdWrite = 1'b0;
  endtask
  task automatic ctl(input logic [7:0] b);
    ctlWrite = 1'b1; ctlByte = b;
    @(negedge clk); ctlWrite = 1'b0;
  endtask
  task automatic prog(input logic [7:0] b);
    portWrite = 1'b1; portWData = b;
    @(negedge clk); portWrite = 1'b0;
  endtask
  task automatic popByte();
    portRead = 1'b1;
    @(negedge clk); portRead = 1'b0;
  endtask
  task automatic rdb(input string req, input logic [7:0] exp);
    chk(req, {8'h0, portRData}, {8'h0, exp});
    popByte();
  endtask
  task automatic stat(input string req, input logic [7:0] exp);
    chk(req, {8'h0, statusByte}, {8'h0, exp});
    statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask
  task automatic eos();
    eosIn = 1'b1;
    @(negedge clk); eosIn = 1'b0;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", {8'h0, statusByte}, 16'h0001);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 R12 nearEmpty", {15'h0, nearEmpty}, 16'h1);

    // vector table: R2 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  op;
      logic [15:0] arg, exp;
      {op, arg, exp} = VEC[i];
      case (op)
        OP_PUSH: push(arg);
        OP_RDB:  rdb("R2 byte order", exp[7:0]);
        OP_STAT: stat("R4 R7 R8 R9 status", exp[7:0]);
        OP_CMD:  cmd(arg[7:0]);
        OP_PROG: prog(arg[7:0]);
        OP_CTL:  ctl(arg[7:0]);
        OP_EOS:  eos();
        default: chk("R10 irq", {15'h0, irq}, exp);
      endcase
    end

    // R12 near-empty level is 2 bytes now
    push(16'h0101);
    chk("R12 at level", {15'h0, nearEmpty}, 16'h1);
    push(16'h0202);
    chk("R12 above level", {15'h0, nearEmpty}, 16'h0);
    cmd(8'h41);

    // R5 data-mode port write ignored, program-mode read pops nothing
    prog(8'h55);
    chk("R5 write in data mode", {8'h0, statusByte}, 16'h0001);
    push(16'hBEEF);
    cmd(8'h00);
    popByte();
    cmd(8'h01);
    rdb("R5 read in program mode", 8'hEF);
    rdb("R5 high byte", 8'hBE);

    // R6 fifth program byte ignored: levels ne=0, nf=4094
    cmd(8'h00);
    prog(8'h00); prog(8'h00); prog(8'hFE); prog(8'h0F); prog(8'hFF);
    cmd(8'h01);
    push(16'h0303);
    chk("R6 near-empty kept", {15'h0, nearEmpty}, 16'h0);
    stat("R6 R7 near-full level", 8'h0A);

    // R3 fill to capacity then overflow
    cmd(8'h41);
    for (int i = 0; i < 2048; i++) push(16'(i));
    stat("R3 R4 full", 8'h0E);
    push(16'hFFFF);
    stat("R3 lost set", 8'h26);
    stat("R3 R9 lost survives read", 8'h26);
    rdb("R3 first sample lo", 8'h00);
    push(16'hEEEE);
    chk("R3 R4 one byte free still full", {8'h0, statusByte}, 16'h0026);
    rdb("R3 first sample hi", 8'h00);
    rdb("R3 second sample lo", 8'h01);
    cmd(8'h41);
    chk("R11 flush clears lost", {8'h0, statusByte}, 16'h0001);

    // R9 event with simultaneous status read stays set; R10 eos irq
    ctl(8'h10);
    eosIn = 1'b1; statusRead = 1'b1;
    @(negedge clk); eosIn = 1'b0; statusRead = 1'b0;
    chk("R9 set wins", {15'h0, statusByte[4]}, 16'h1);
    chk("R10 eos irq", {15'h0, irq}, 16'h1);
    stat("R9 read", 8'h11);
    chk("R9 cleared", {15'h0, irq}, 16'h0);

    finish();
  end
endmodule